// File: doc/BRIEF.md
# Hypercube Next-Hop Selector

This block makes the routing decision for one hop inside a switch of a K-dimensional binary hypercube network. Each request carries the label of the node the packet sits on and the label of its destination. The block answers with the one dimension the packet must cross next. The answer comes as a bit index and as a one-hot flip mask, together with the neighbour label reached by that crossing and a flag that marks arrival. Only dimensions in which the two labels differ are ever chosen, so every route is a shortest path. The choice depends only on the current and destination labels, so the route is oblivious.

The dimension comes from the difference vector, which is the current label XOR the destination label. The block looks at every leftward cyclic rotation of that vector and keeps the one with the smallest unsigned value. When several rotation amounts tie, the smallest amount wins. The block then flips the original bit that lands on the leftmost 1 of the winning rotation. After the first hop, the remaining flips move left to right and wrap around. A switch that knows on which dimension a packet arrived can therefore ask for a cheaper cyclic scan that starts from that dimension. Requests enter through a valid/ready handshake, and every result leaves from one output register stage.

Top module: `hc_next_hop`

## Requirements
- R1: When the current and destination labels are equal, the result has out_done=1, out_mask all zeros, out_dim=0 and out_next equal to the current label.
- R2: When the labels differ, out_mask has exactly one bit set, and that bit is set in the difference vector (current XOR destination).
- R3: Bit index 0 is the rightmost (least significant) bit and bit K-1 is the leftmost. Position p counts from the left, starting at 0. Among the left rotations by r = 0..K-1 of the difference vector, the block takes the one with the least unsigned value, using the smallest r on ties. With its leftmost 1 at position p, the block selects left position (p+r) mod K, which is bit index K-1-((p+r) mod K). out_mask is 1 shifted left by out_dim.
- R4: For K=4, current 0000 and destination 0101 give out_next=0100 (out_dim=2), not 0001.
- R5: An all-ones difference vector selects the leftmost bit, index K-1.
- R6: out_next equals the current label XOR out_mask.
- R7: When in_use_port=1, the block scans from bit index in_arr_dim toward lower indices, wrapping from 0 to K-1, and selects the first set bit of the difference vector. On every non-origin hop of a route, with the arrival dimension given, this result equals the R3 result.
- R8: Repeated application from any source reaches any destination in exactly popcount(source XOR destination) hops.
- R9: A result is valid in the cycle after its request is accepted (in_valid and in_ready both high at a clock edge).
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold steady. No request is dropped or duplicated.
- R11: After reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_cur | input | K | Label of the current node |
| in_dst | input | K | Label of the destination node |
| in_use_port | input | 1 | Use the arrival-port cyclic scan |
| in_arr_dim | input | $clog2(K) | Dimension the packet arrived on |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dim | output | $clog2(K) | Selected dimension index |
| out_mask | output | K | One-hot flip mask, zero on arrival |
| out_next | output | K | Neighbour label after the flip |
| out_done | output | 1 | Packet already at its destination |

## Verification
The agreement check between the cyclic scan and the rotation search assumes that in_use_port is raised only together with a truthful arrival dimension, and only on hops after the first. The bench keeps to this. It asserts in_use_port only while walking a route, and passes the dimension that the previous hop returned. On origin hops and in the directed tests the flag stays low. The other properties assume nothing about the labels.

// File: rtl/hc_route_pkg.sv
package hc_route_pkg;
  // Source of the selected dimension, brought out for the checker
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROT  = 2'd1,
    SEL_PORT = 2'd2
  } hc_sel_e;

  // Cyclic wrap of a non-negative value into [0, k)
  function automatic int hc_wrap(input int v, input int k);
    return v % k;
  endfunction
endpackage

// File: rtl/hc_rot_search.sv
// Least-rotation search: picks the bit that maps to the leftmost 1
// of the minimal cyclic left rotation (smallest amount on ties).
module hc_rot_search #(
  parameter int K  = 4,
  parameter int IW = $clog2(K)
) (
  input  logic [K-1:0]  diff,
  output logic [IW-1:0] rot_dim
);
  import hc_route_pkg::*;

  logic [K-1:0] rots [K];

  generate
    for (genvar r = 0; r < K; r++) begin : g_rot
      if (r == 0) begin : g_id
        assign rots[r] = diff;
      end else begin : g_sh
        assign rots[r] = (diff << r) | (diff >> (K - r));
      end
    end
  endgenerate

  always_comb begin
    logic [K-1:0] best;
    int best_r;
    int lead;
    logic found;
    best   = rots[0];
    best_r = 0;
    for (int r = 1; r < K; r++) begin
      if (rots[r] < best) begin
        best   = rots[r];
        best_r = r;
      end
    end
    lead  = 0;
    found = 1'b0;
    for (int p = 0; p < K; p++) begin
      if (!found && best[K-1-p]) begin
        lead  = p;
        found = 1'b1;
      end
    end
    rot_dim = IW'(K - 1 - hc_wrap(lead + best_r, K));
  end
endmodule

// File: rtl/hc_port_scan.sv
// Port-aware scan: next set bit below the arrival dimension, wrapping.
module hc_port_scan #(
  parameter int K  = 4,
  parameter int IW = $clog2(K)
) (
  input  logic [K-1:0]  diff,
  input  logic [IW-1:0] arr_dim,
  output logic [IW-1:0] scan_dim
);
  import hc_route_pkg::*;

  always_comb begin
    logic found;
    int j;
    scan_dim = '0;
    found    = 1'b0;
    for (int s = 1; s <= K; s++) begin
      j = hc_wrap(int'(arr_dim) + K - s, K);
      if (!found && diff[j]) begin
        scan_dim = IW'(j);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hc_out_stage.sv
// Single output register with valid/ready back-pressure.
module hc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_next_hop.sv
module hc_next_hop #(
  parameter int K  = 4,
  parameter int IW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [K-1:0]  in_cur,
  input  logic [K-1:0]  in_dst,
  input  logic          in_use_port,
  input  logic [IW-1:0] in_arr_dim,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_dim,
  output logic [K-1:0]  out_mask,
  output logic [K-1:0]  out_next,
  output logic          out_done
);
  import hc_route_pkg::*;

  localparam int PW = IW + 2 * K + 1;

  // Named internal events for the checker
  logic [K-1:0]  diff;
  logic          arrived;
  logic [IW-1:0] rot_dim;
  logic [IW-1:0] scan_dim;
  logic [IW-1:0] sel_dim;
  logic [K-1:0]  sel_mask;
  logic [K-1:0]  sel_next;
  hc_sel_e       sel_src;
  logic          accept;
  logic          stage_full;
  logic [PW-1:0] stage_in;
  logic [PW-1:0] stage_q;

  assign diff    = in_cur ^ in_dst;
  assign arrived = (diff == '0);

  hc_rot_search #(.K(K), .IW(IW)) rot_i (
    .diff    (diff),
    .rot_dim (rot_dim)
  );

  hc_port_scan #(.K(K), .IW(IW)) scan_i (
    .diff     (diff),
    .arr_dim  (in_arr_dim),
    .scan_dim (scan_dim)
  );

  always_comb begin
    if (arrived)          sel_src = SEL_NONE;
    else if (in_use_port) sel_src = SEL_PORT;
    else                  sel_src = SEL_ROT;
    case (sel_src)
      SEL_ROT:  sel_dim = rot_dim;
      SEL_PORT: sel_dim = scan_dim;
      default:  sel_dim = '0;
    endcase
    sel_mask = (sel_src == SEL_NONE) ? '0 : (K'(1) << sel_dim);
    sel_next = in_cur ^ sel_mask;
  end

  assign in_ready = !stage_full || out_ready;
  assign accept   = in_valid && in_ready;
  assign stage_in = {sel_dim, sel_mask, sel_next, arrived};

  hc_out_stage #(.W(PW)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (stage_in),
    .take      (out_ready),
    .full      (stage_full),
    .data      (stage_q)
  );

  assign out_valid = stage_full;
  assign {out_dim, out_mask, out_next, out_done} = stage_q;
endmodule

// File: rtl/hc_next_hop_chk.sv
module hc_next_hop_chk #(
  parameter int K  = 4,
  parameter int IW = $clog2(K)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [K-1:0]  in_cur,
  input logic          in_use_port,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_dim,
  input logic [K-1:0]  out_mask,
  input logic [K-1:0]  out_next,
  input logic          out_done,
  input logic [K-1:0]  diff,
  input logic [IW-1:0] rot_dim,
  input logic [IW-1:0] scan_dim,
  input logic          accept
);
  assert_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_done |-> out_mask == '0);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_done |-> $countones(out_mask) == 1);

  assert_shortest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_mask & ~$past(diff)) == '0);

  assert_dimmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_done |-> ((out_mask >> out_dim) & K'(1)) == K'(1));

  assert_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_next == ($past(in_cur) ^ out_mask));

  assert_port_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_use_port && diff != '0 |-> scan_dim == rot_dim);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next)
      && $stable(out_mask) && $stable(out_dim) && $stable(out_done));
endmodule

bind hc_next_hop hc_next_hop_chk #(.K(K), .IW(IW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_cur      (in_cur),
  .in_use_port (in_use_port),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_dim     (out_dim),
  .out_mask    (out_mask),
  .out_next    (out_next),
  .out_done    (out_done),
  .diff        (diff),
  .rot_dim     (rot_dim),
  .scan_dim    (scan_dim),
  .accept      (accept)
);

// File: tb/hc_next_hop_tb.sv
module hc_next_hop_tb_top;
  localparam int K  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [K-1:0]  in_cur = '0;
  logic [K-1:0]  in_dst = '0;
  logic          in_use_port = 1'b0;
  logic [IW-1:0] in_arr_dim = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [IW-1:0] out_dim;
  logic [K-1:0]  out_mask;
  logic [K-1:0]  out_next;
  logic          out_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hc_next_hop #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cur(in_cur), .in_dst(in_dst), .in_use_port(in_use_port),
    .in_arr_dim(in_arr_dim), .out_valid(out_valid), .out_ready(out_ready),
    .out_dim(out_dim), .out_mask(out_mask), .out_next(out_next),
    .out_done(out_done)
  );

  // {cur, dst, expected mask}
  localparam logic [11:0] VEC [8] = '{
    {4'b0000, 4'b0101, 4'b0100},  // R4 worked case
    {4'b0000, 4'b1111, 4'b1000},  // R5 all ones -> leftmost
    {4'b1001, 4'b1001, 4'b0000},  // R1 arrived
    {4'b1010, 4'b1011, 4'b0001},  // R3 single bit
    {4'b0000, 4'b0110, 4'b0100},  // R3 min at r=3
    {4'b1111, 4'b0101, 4'b0010},  // R3 periodic tie, r=1 wins
    {4'b0011, 4'b1110, 4'b0001},  // R3 min at r=2
    {4'b0100, 4'b1100, 4'b1000}   // R3 min at r=1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference: scan a doubled copy for the least rotation
  function automatic int ref_dim(input logic [3:0] d);
    logic [7:0] dd;
    logic [3:0] v;
    logic [3:0] best_v;
    int best_r;
    int p;
    dd = {d, d};
    best_v = dd[7 -: 4];
    best_r = 0;
    for (int r = 1; r < 4; r++) begin
      v = dd[7-r -: 4];
      if (v < best_v) begin
        best_v = v;
        best_r = r;
      end
    end
    p = 3;
    for (int i = 3; i >= 0; i--) if (best_v[3-i]) p = i;
    return 3 - ((p + best_r) % 4);
  endfunction

  task automatic do_req(input logic [3:0] c, input logic [3:0] d,
                        input logic up, input logic [1:0] a);
    @(negedge clk);
    in_cur = c; in_dst = d; in_use_port = up; in_arr_dim = a; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_use_port = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 idle after reset",
          {out_valid, in_ready}, 1);

    // Vector table
    foreach (VEC[i]) begin
      do_req(VEC[i][11:8], VEC[i][7:4], 1'b0, 2'd0);
      check(out_valid && out_mask == VEC[i][3:0], "R3 vector mask",
            out_mask, VEC[i][3:0]);
      check(out_next == (VEC[i][11:8] ^ VEC[i][3:0]), "R6 vector next",
            out_next, VEC[i][11:8] ^ VEC[i][3:0]);
      check(out_done == (VEC[i][3:0] == 4'b0), "R1 vector done",
            out_done, VEC[i][3:0] == 4'b0);
    end

    // R8 / R7 / R2: exhaustive walks, port-aware mode on non-origin hops
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        logic [3:0] cur;
        logic [1:0] prev;
        bit first;
        bit fin;
        int hops;
        int exp;
        cur = 4'(s); prev = '0; first = 1'b1; fin = 1'b0; hops = 0;
        for (int h = 0; h < 6 && !fin; h++) begin
          do_req(cur, 4'(d), !first, prev);
          if ((cur ^ 4'(d)) == 4'b0) begin
            check(out_valid && out_done && out_mask == 4'b0, "R1 walk end",
                  out_mask, 0);
            fin = 1'b1;
          end else begin
            exp = ref_dim(cur ^ 4'(d));
            check(out_valid && !out_done && int'(out_dim) == exp &&
                  out_next == (cur ^ (4'b1 << exp)),
                  first ? "R3 origin hop" : "R7 port-aware hop",
                  out_dim, exp);
            cur = out_next; prev = out_dim; first = 1'b0; hops++;
          end
        end
        check(fin && hops == $countones(4'(s) ^ 4'(d)), "R8 hop count",
              hops, $countones(4'(s) ^ 4'(d)));
      end
    end

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_cur = 4'b0000; in_dst = 4'b0110; in_use_port = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_next == 4'b0100, "R9 first result", out_next, 4'b0100);
    in_dst = 4'b1000;
    check(in_ready == 1'b0, "R10 ready low while full", in_ready, 0);
    repeat (3) @(negedge clk);
    check(out_valid && out_next == 4'b0100 && in_ready == 1'b0,
          "R10 held result", out_next, 4'b0100);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_next == 4'b1000, "R10 stalled request delivered",
          out_next, 4'b1000);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 no duplicate", out_valid, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule